// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Counter with Scanned Display

This block keeps a two-digit decimal count, a tens digit and a units digit, each held as a 4-bit BCD value. An internal divider turns the system clock into a one-cycle tick once per `TICK_DIV` cycles. The default of 100,000,000 gives one tick per second at 100 MHz. On each tick the count steps by one, either up or down, when counting is enabled. Counting up wraps from 99 to 00, and counting down wraps from 00 to 99. A pushbutton input clears the count to 00. A scanner shows the count on an eight-position common-anode seven-segment array. It lights one position per slot of `SCAN_DIV` cycles. The units digit sits on the rightmost position, the tens digit on the one to its left, and the other six positions stay dark.

The button and the two switch inputs each pass through a two-flop synchronizer. The control is a four-state mode machine:
- `ST_CLEAR`: the button is held.
- `ST_HOLD`: counting is disabled.
- `ST_UP`: counting up.
- `ST_DOWN`: counting down.

The transitions are:
- Any state goes to `ST_CLEAR` while the synchronized button is 1.
- Any state goes to `ST_HOLD` when the button is 0 and the enable switch is 0.
- Any state goes to `ST_UP` when the button is 0, the enable switch is 1 and the direction switch is 1.
- Any state goes to `ST_DOWN` when the button is 0, the enable switch is 1 and the direction switch is 0.

The register contents are undefined at power-up, so the button must be pressed once before use.

Top module: `bcd_updown_top`

## Requirements
- R1: With `sw_enable`=1 and `sw_up`=1, each tick raises the displayed value by one, in decimal.
- R2: With `sw_enable`=1 and `sw_up`=0, each tick lowers the displayed value by one, in decimal.
- R3: Counting up from 99 gives 00.
- R4: Counting down from 00 gives 99.
- R5: With `sw_enable`=0, the value does not change across ticks.
- R6: Holding `btn_clear` at 1 sets both digits to 0. Counting then resumes from 00 after release.
- R7: The count changes exactly once per `TICK_DIV` clock cycles, and never between ticks.
- R8: The units digit is shown while `an_n[0]` is 0 and the tens digit while `an_n[1]` is 0. Segments are active-low with bit order `seg_n[6:0]` = g,f,e,d,c,b,a. For example, digit 0 is 1000000 and digit 1 is 1111001.
- R9: `an_n[7:2]` stay 1 at all times. In any slot where no anode is low, `seg_n` is 1111111.
- R10: At most one anode is low in any cycle.
- R11: Each digit always holds a BCD value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| btn_clear | input | 1 | Clear button, active high, asynchronous to `clk` |
| sw_enable | input | 1 | 1 = count on each tick, 0 = hold |
| sw_up | input | 1 | 1 = count up, 0 = count down |
| seg_n | output | 7 | Segment drives g..a, active low |
| an_n | output | DIGITS (8) | Position anodes, active low, bit 0 rightmost |

## Verification
The assertions are disabled until the synchronized clear has been seen once, because no state is defined before the first press. The assertions also assume that the switch inputs hold still long enough to pass the synchronizers. The bench changes switches only mid-way between ticks, and it holds the button for several cycles. After each release it realigns its timing to the tick. It then samples the display over one full scan, late in each tick period, so every reading falls in a window where the count is stable.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_HOLD  = 2'd1,
        ST_UP    = 2'd2,
        ST_DOWN  = 2'd3
    } mode_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd2_t;

    localparam logic [6:0] SEG_DARK = 7'h7F;

    // one BCD step up, units carry into tens in the same cycle
    function automatic bcd2_t bcd_step_up(bcd2_t v);
        bcd2_t r;
        r = v;
        if (v.units == 4'd9) begin
            r.units = 4'd0;
            r.tens  = (v.tens == 4'd9) ? 4'd0 : v.tens + 4'd1;
        end else begin
            r.units = v.units + 4'd1;
        end
        return r;
    endfunction

    // one BCD step down, units borrow from tens in the same cycle
    function automatic bcd2_t bcd_step_down(bcd2_t v);
        bcd2_t r;
        r = v;
        if (v.units == 4'd0) begin
            r.units = 4'd9;
            r.tens  = (v.tens == 4'd0) ? 4'd9 : v.tens - 4'd1;
        end else begin
            r.units = v.units - 4'd1;
        end
        return r;
    endfunction

    // active-low segments, bit order g f e d c b a
    function automatic logic [6:0] seg_encode(logic [3:0] d);
        logic [6:0] s;
        unique case (d)
            4'd0: s = 7'b1000000;
            4'd1: s = 7'b1111001;
            4'd2: s = 7'b0100100;
            4'd3: s = 7'b0110000;
            4'd4: s = 7'b0011001;
            4'd5: s = 7'b0010010;
            4'd6: s = 7'b0000010;
            4'd7: s = 7'b1111000;
            4'd8: s = 7'b0000000;
            4'd9: s = 7'b0010000;
            default: s = SEG_DARK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcd_sync2.sv
module bcd_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        meta_q <= d_async;
        sync_q <= meta_q;
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/bcd_tick_gen.sv
module bcd_tick_gen #(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !clr && (cnt_q == LAST);
endmodule

// File: rtl/bcd_count_core.sv
module bcd_count_core
    import bcd_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  en,
    input  logic  up,
    input  logic  tick,
    output mode_t mode,
    output bcd2_t count
);
    mode_t mode_q;
    mode_t mode_d;
    mode_t run_mode;
    bcd2_t count_q;

    always_comb begin
        if (!en) begin
            run_mode = ST_HOLD;
        end else if (up) begin
            run_mode = ST_UP;
        end else begin
            run_mode = ST_DOWN;
        end
    end

    // transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_CLEAR: mode_d = clr ? ST_CLEAR : run_mode;
            ST_HOLD,
            ST_UP,
            ST_DOWN:  mode_d = clr ? ST_CLEAR : run_mode;
            default:  mode_d = ST_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        unique case (mode_q)
            ST_CLEAR: count_q <= '0;
            ST_HOLD:  count_q <= count_q;
            ST_UP:    if (tick) count_q <= bcd_step_up(count_q);
            ST_DOWN:  if (tick) count_q <= bcd_step_down(count_q);
            default:  count_q <= '0;
        endcase
    end

    assign mode  = mode_q;
    assign count = count_q;
endmodule

// File: rtl/bcd_scan.sv
module bcd_scan
    import bcd_pkg::*;
#(
    parameter int DIGITS   = 8,
    parameter int SCAN_DIV = 100_000
) (
    input  logic              clk,
    input  logic              clr,
    input  bcd2_t             count,
    output logic [6:0]        seg_n,
    output logic [DIGITS-1:0] an_n
);
    localparam int SHOWN = 2;
    localparam int RW    = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam int IW    = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [RW-1:0] REF_LAST = RW'(SCAN_DIV - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DIGITS - 1);

    logic [RW-1:0]     ref_q;
    logic [IW-1:0]     idx_q;
    logic [3:0]        val;
    logic              show;
    logic [6:0]        seg_d;
    logic [DIGITS-1:0] an_d;
    logic [6:0]        seg_q;
    logic [DIGITS-1:0] an_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            ref_q <= '0;
            idx_q <= '0;
        end else if (ref_q == REF_LAST) begin
            ref_q <= '0;
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end else begin
            ref_q <= ref_q + 1'b1;
        end
    end

    always_comb begin
        show = (32'(idx_q) < SHOWN);
        val  = (idx_q == '0) ? count.units : count.tens;
        seg_d = show ? seg_encode(val) : SEG_DARK;
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_anode
        if (g < SHOWN) begin : g_live
            assign an_d[g] = !(idx_q == IW'(g));
        end else begin : g_dark
            assign an_d[g] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            seg_q <= SEG_DARK;
            an_q  <= '1;
        end else begin
            seg_q <= seg_d;
            an_q  <= an_d;
        end
    end

    assign seg_n = seg_q;
    assign an_n  = an_q;
endmodule

// File: rtl/bcd_updown_top.sv
module bcd_updown_top
    import bcd_pkg::*;
#(
    parameter int TICK_DIV = 100_000_000,
    parameter int SCAN_DIV = 100_000,
    parameter int DIGITS   = 8
) (
    input  logic              clk,
    input  logic              btn_clear,
    input  logic              sw_enable,
    input  logic              sw_up,
    output logic [6:0]        seg_n,
    output logic [DIGITS-1:0] an_n
);
    logic [2:0] raw_in;
    logic [2:0] sync_in;
    logic       clr_s;
    logic       en_s;
    logic       up_s;
    logic       tick;
    mode_t      mode;
    bcd2_t      count;

    assign raw_in = {btn_clear, sw_enable, sw_up};
    assign clr_s  = sync_in[2];
    assign en_s   = sync_in[1];
    assign up_s   = sync_in[0];

    bcd_sync2 #(.W(3)) i_sync (
        .clk     (clk),
        .d_async (raw_in),
        .d_sync  (sync_in)
    );

    bcd_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk  (clk),
        .clr  (clr_s),
        .tick (tick)
    );

    bcd_count_core i_core (
        .clk   (clk),
        .clr   (clr_s),
        .en    (en_s),
        .up    (up_s),
        .tick  (tick),
        .mode  (mode),
        .count (count)
    );

    bcd_scan #(.DIGITS(DIGITS), .SCAN_DIV(SCAN_DIV)) i_scan (
        .clk   (clk),
        .clr   (clr_s),
        .count (count),
        .seg_n (seg_n),
        .an_n  (an_n)
    );
endmodule

// File: rtl/bcd_updown_chk.sv
module bcd_updown_chk
    import bcd_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input logic              clk,
    input logic              clr_s,
    input logic              tick,
    input mode_t             mode,
    input bcd2_t             count,
    input logic [6:0]        seg_n,
    input logic [DIGITS-1:0] an_n
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (clr_s) armed <= 1'b1;
    end

    function automatic int unsigned as_dec(bcd2_t c);
        return 32'(c.tens) * 10 + 32'(c.units);
    endfunction

    assert_step_up_R1: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (tick && mode == ST_UP) |=> as_dec(count) == (as_dec($past(count)) + 1) % 100);

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (tick && mode == ST_DOWN) |=> as_dec(count) == (as_dec($past(count)) + 99) % 100);

    assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (tick && mode == ST_UP && as_dec(count) == 99) |=> as_dec(count) == 0);

    assert_wrap_down_R4: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (tick && mode == ST_DOWN && as_dec(count) == 0) |=> as_dec(count) == 99);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (mode == ST_HOLD) |=> $stable(count));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (mode == ST_CLEAR) |=> as_dec(count) == 0);

    assert_no_step_between_ticks_R7: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (!tick && mode != ST_CLEAR) |=> $stable(count));

    assert_unused_dark_R9: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (&an_n[DIGITS-1:2]) && ((&an_n) -> (seg_n == SEG_DARK)));

    assert_one_anode_R10: assert property (@(posedge clk) disable iff (!armed || clr_s)
        $onehot0(~an_n));

    assert_bcd_range_R11: assert property (@(posedge clk) disable iff (!armed || clr_s)
        (count.units <= 4'd9) && (count.tens <= 4'd9));
endmodule

bind bcd_updown_top bcd_updown_chk #(.DIGITS(DIGITS)) i_chk (
    .clk   (clk),
    .clr_s (clr_s),
    .tick  (tick),
    .mode  (mode),
    .count (count),
    .seg_n (seg_n),
    .an_n  (an_n)
);

// File: tb/test_bcd_updown_top.sv
module test_bcd_updown_top;
    localparam int TICK_DIV = 200;
    localparam int SCAN_DIV = 4;
    localparam int DIGITS   = 8;
    localparam int READ_LEN = DIGITS * SCAN_DIV;

    logic              clk = 1'b0;
    logic              btn_clear = 1'b0;
    logic              sw_enable = 1'b0;
    logic              sw_up = 1'b0;
    logic [6:0]        seg_n;
    logic [DIGITS-1:0] an_n;

    int n_checks = 0;
    int n_fail   = 0;
    int expv     = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bcd_updown_top #(.TICK_DIV(TICK_DIV), .SCAN_DIV(SCAN_DIV), .DIGITS(DIGITS)) i_bcd_updown_top (
        .clk       (clk),
        .btn_clear (btn_clear),
        .sw_enable (sw_enable),
        .sw_up     (sw_up),
        .seg_n     (seg_n),
        .an_n      (an_n)
    );

    // segment pattern from the lit-segment list of each digit
    function automatic logic [6:0] expect_seg(int d);
        logic [6:0] on;
        case (d)
            0: on = 7'b0111111;
            1: on = 7'b0000110;
            2: on = 7'b1011011;
            3: on = 7'b1001111;
            4: on = 7'b1100110;
            5: on = 7'b1101101;
            6: on = 7'b1111101;
            7: on = 7'b0000111;
            8: on = 7'b1111111;
            9: on = 7'b1101111;
            default: on = 7'b0000000;
        endcase
        return ~on;
    endfunction

    function automatic int next_val(int v, bit en, bit up);
        if (!en) return v;
        return up ? (v + 1) % 100 : (v + 99) % 100;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // observes one full scan and compares against expv
    task automatic read_and_check(string tag);
        logic [6:0] u = 7'h7F;
        logic [6:0] t = 7'h7F;
        int bad = 0;
        repeat (READ_LEN) begin
            @(negedge clk);
            if (!$onehot0(~an_n)) bad++;
            if (!(&an_n[DIGITS-1:2])) bad++;
            if ((&an_n) && seg_n != 7'h7F) bad++;
            if (!an_n[0]) u = seg_n;
            if (!an_n[1]) t = seg_n;
        end
        check(bad == 0, "R9/R10", "blank/anode violations", bad, 0);
        check(u == expect_seg(expv % 10), tag, "units segs", int'(u), int'(expect_seg(expv % 10)));
        check(t == expect_seg(expv / 10), tag, "tens segs", int'(t), int'(expect_seg(expv / 10)));
    endtask

    task automatic press_clear();
        @(negedge clk);
        btn_clear = 1'b1;
        repeat (8) @(negedge clk);
        btn_clear = 1'b0;
        expv = 0;
        repeat (2 + TICK_DIV / 2 - READ_LEN) @(negedge clk);
        read_and_check("R6 clear R8");
    endtask

    task automatic step(bit en, bit up);
        string tag;
        sw_enable = en;
        sw_up     = up;
        if (!en) tag = "R5 hold R7";
        else if (up && expv == 99) tag = "R3 wrap-up R7";
        else if (!up && expv == 0) tag = "R4 wrap-down R7";
        else if (up) tag = "R1 up R7 R8 R11";
        else tag = "R2 down R7 R8 R11";
        expv = next_val(expv, en, up);
        repeat (TICK_DIV - READ_LEN) @(negedge clk);
        read_and_check(tag);
    endtask

    initial begin
        void'($urandom(32'd4133));
        repeat (3) @(negedge clk);
        press_clear();
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 220; i++) begin
            bit en = ($urandom_range(0, 3) != 0);
            bit up = $urandom_range(0, 1) == 1;
            if (i == 110) press_clear();
            step(en, up);
        end
        press_clear();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150_000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule